// File: doc/BRIEF.md
# Stereo Digital Volume and Channel Control

This stage sits in a sample-rate audio datapath. It takes one stereo pair of 24-bit signed PCM samples per valid strobe and scales each output channel by its own attenuation. The attenuation is set by a 6-bit code in 1 dB steps from 0 dB, which is full scale, down to -60 dB. Codes beyond -60 dB silence the channel outright. An optional swap exchanges the two channels before scaling. A soft mute fades the output to silence over 32 samples, and releasing it fades back up the same way, so the output never steps.

The gains come from a table computed at elaboration from 10^(-n/20). Each entry is an 18-bit unsigned fraction where 2^17 means unity. The fade position multiplies the table gain. The product is rounded and clamped to 24 bits. The control inputs are only sampled together with a valid sample, so a volume change always lands on a sample boundary.

Top module: `stereo_atten`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid is 0 and both output samples are 0. The fade position resets to full (32 of 32).
- R2: A sample pair accepted with in_valid high in cycle c appears with out_valid high in cycle c+2. In cycles where out_valid is low, out_l and out_r keep their last value.
- R3: A volume code n from 0 to 60 selects the gain G(n) = round(131072 * 10^(-n/20)). Code 0 gives G = 131072, which passes the sample through unchanged.
- R4: Volume codes 61, 62 and 63 select gain 0, so that output channel is exactly 0.
- R5: vol_l scales out_l and vol_r scales out_r, each on its own.
- R6: With swap = 0, out_l is derived from in_l and out_r from in_r. With swap = 1, out_l is derived from in_r and out_r from in_l. The volume codes belong to the output channels.
- R7: Each output is (s * E + 2^16) >>> 17, where s is the selected input sample and E is the effective gain. The result is then clamped to the range -8388608 to 8388607.
- R8: Each accepted sample first steps the fade position k, then uses it. With mute = 1, k steps down by 1 toward 0, so 32 consecutive muted samples reach silence. The effective gain is E = floor(G * k / 32).
- R9: With mute = 0, each accepted sample steps k up by 1 toward 32. After 32 unmuted samples the full gain is restored.
- R10: in_l, in_r, vol_l, vol_r, mute and swap have no effect in cycles where in_valid is low. The fade position only moves on accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample pair is present this cycle |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| vol_l | input | 6 | Attenuation code for the left output, in dB |
| vol_r | input | 6 | Attenuation code for the right output, in dB |
| mute | input | 1 | Soft mute request |
| swap | input | 1 | Exchange the left and right channels |
| out_valid | output | 1 | Output sample pair is valid |
| out_l | output | 24 | Left output sample |
| out_r | output | 24 | Right output sample |

## Verification
The bench sweeps all 64 codes with full-scale positive and negative samples.
- A table built with the wrong exponent, or one that lets codes 61 to 63 leak through, gives wrong output levels.
- An off-by-one fade counter ends short of silence or stops one step below unity after the 32-sample ramps.
- A design that latches controls outside valid cycles takes a volume or swap change made between samples.
- A design that moves the ramp on idle cycles drifts during gaps in the sample stream.
- Small odd samples such as -1 and 1 expose truncation where the block should round.

// File: rtl/stereo_atten.sv
module stereo_atten #(
  parameter int DW       = 24,
  parameter int GW       = 18,
  parameter int VW       = 6,
  parameter int MAX_ATT  = 60,
  parameter int RAMP_LOG = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  input  logic [VW-1:0]        vol_l,
  input  logic [VW-1:0]        vol_r,
  input  logic                 mute,
  input  logic                 swap,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r
);
  localparam int UNITY = 1 << (GW - 1);
  localparam int CODES = 1 << VW;
  localparam int PW    = DW + GW + 1;
  localparam int KW    = RAMP_LOG + 1;
  localparam logic [KW-1:0] RAMP = KW'(1 << RAMP_LOG);
  localparam logic signed [PW-1:0] HI = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GW - 2);

  function automatic int gain_of(int n);
    real g;
    if (n > MAX_ATT) return 0;
    g = real'(UNITY) * (10.0 ** (-real'(n) / 20.0));
    return $rtoi(g + 0.5);
  endfunction

  logic [GW-1:0] gtab [CODES];
  for (genvar i = 0; i < CODES; i++) begin : g_tab
    assign gtab[i] = GW'(gain_of(i));
  end

  logic [KW-1:0] rc, rc_nx;
  always_comb begin
    if (mute) rc_nx = (rc == '0) ? rc : rc - KW'(1);
    else      rc_nx = (rc == RAMP) ? rc : rc + KW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)           rc <= RAMP;
    else if (in_valid) rc <= rc_nx;
  end

  logic [GW+KW-1:0] sc_l, sc_r;
  assign sc_l = (GW+KW)'(gtab[vol_l]) * (GW+KW)'(rc_nx);
  assign sc_r = (GW+KW)'(gtab[vol_r]) * (GW+KW)'(rc_nx);

  logic                 v1;
  logic signed [DW-1:0] a_l, a_r;
  logic [GW-1:0]        g_l, g_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1  <= 1'b0;
      a_l <= '0;
      a_r <= '0;
      g_l <= '0;
      g_r <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        a_l <= swap ? in_r : in_l;
        a_r <= swap ? in_l : in_r;
        g_l <= GW'(sc_l >> RAMP_LOG);
        g_r <= GW'(sc_r >> RAMP_LOG);
      end
    end
  end

  function automatic logic signed [DW-1:0] scale(logic signed [DW-1:0] s, logic [GW-1:0] g);
    logic signed [PW-1:0] se, ge, p, r;
    se = PW'(s);
    ge = PW'({1'b0, g});
    p  = se * ge;
    r  = (p + HALF) >>> (GW - 1);
    if (r > HI) r = HI;
    if (r < LO) r = LO;
    return r[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_l <= scale(a_l, g_l);
        out_r <= scale(a_r, g_r);
      end
    end
  end
endmodule

// File: rtl/stereo_atten_chk.sv
module stereo_atten_chk #(
  parameter int DW       = 24,
  parameter int VW       = 6,
  parameter int MAX_ATT  = 60,
  parameter int RAMP_LOG = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_l,
  input logic [VW-1:0]        vol_l,
  input logic [VW-1:0]        vol_r,
  input logic                 mute,
  input logic                 swap,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic [RAMP_LOG:0]    ramp
);
  localparam logic [RAMP_LOG:0] FULL = (RAMP_LOG+1)'(1 << RAMP_LOG);

  AST_LATENCY_ON:  assert property (@(posedge clk) disable iff (rst) in_valid |=> ##1 out_valid);  // R2
  AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ##1 !out_valid); // R2
  AST_OUT_HOLD:    assert property (@(posedge clk) disable iff (rst)
                     !out_valid |-> $stable(out_l) && $stable(out_r));                              // R2
  AST_HARD_MUTE_L: assert property (@(posedge clk) disable iff (rst)
                     in_valid && vol_l > VW'(MAX_ATT) |=> ##1 out_l == '0);                         // R4
  AST_HARD_MUTE_R: assert property (@(posedge clk) disable iff (rst)
                     in_valid && vol_r > VW'(MAX_ATT) |=> ##1 out_r == '0);                         // R4
  AST_UNITY_PASS:  assert property (@(posedge clk) disable iff (rst)
                     in_valid && vol_l == '0 && !swap && !mute && ramp == FULL
                     |=> ##1 out_l == $past(in_l, 2));                                              // R3
  AST_RAMP_IDLE:   assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(ramp));  // R10
  AST_RAMP_DOWN:   assert property (@(posedge clk) disable iff (rst)
                     in_valid && mute |=> ramp <= $past(ramp));                                     // R8
  AST_RAMP_UP:     assert property (@(posedge clk) disable iff (rst)
                     in_valid && !mute |=> ramp >= $past(ramp) && ramp <= FULL);                    // R9
endmodule

bind stereo_atten stereo_atten_chk #(
  .DW(DW), .VW(VW), .MAX_ATT(MAX_ATT), .RAMP_LOG(RAMP_LOG)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_l(in_l), .vol_l(vol_l), .vol_r(vol_r),
  .mute(mute), .swap(swap), .out_valid(out_valid), .out_l(out_l), .out_r(out_r), .ramp(rc)
);

// File: tb/sim_stereo_atten.sv
`timescale 1ns/1ps
module sim_stereo_atten;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic [5:0] vol_l = '0, vol_r = '0;
  logic mute = 1'b0, swap = 1'b0;
  logic out_valid;
  logic signed [23:0] out_l, out_r;

  int compared = 0, mismatched = 0;
  string tag = "R1 reset";
  bit done = 0;

  always #10 clk = ~clk;

  stereo_atten u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .vol_l(vol_l), .vol_r(vol_r), .mute(mute), .swap(swap),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
  );

  function automatic longint ref_gain(int code);
    if (code > 60) return 0;
    return longint'($rtoi(131072.0 * (10.0 ** (-real'(code) / 20.0)) + 0.5));
  endfunction

  function automatic int ref_out(int s, int code, int k);
    longint e, p, r;
    e = (ref_gain(code) * k) >> 5;
    p = longint'(s) * e;
    r = (p + 65536) >>> 17;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return int'(r);
  endfunction

  // behavioural reference: one pending pair, fade position, held outputs
  int ev = 0, el = 0, er = 0, ql = 0, qr = 0, rk = 32;
  bit qv = 0;
  always @(posedge clk) begin
    if (rst) begin
      ev = 0; el = 0; er = 0; qv = 0; rk = 32;
    end else begin
      ev = qv;
      if (qv) begin el = ql; er = qr; end
      qv = in_valid;
      if (in_valid) begin
        if (mute) rk = (rk > 0) ? rk - 1 : 0;
        else      rk = (rk < 32) ? rk + 1 : 32;
        ql = ref_out(swap ? int'(in_r) : int'(in_l), int'(vol_l), rk);
        qr = ref_out(swap ? int'(in_l) : int'(in_r), int'(vol_r), rk);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (out_valid !== ev[0] || int'(out_l) != el || int'(out_r) != er) begin
        mismatched++;
        $display("FAIL %s: valid=%0b l=%0d r=%0d expected valid=%0d l=%0d r=%0d",
                 tag, out_valid, out_l, out_r, ev, el, er);
      end
    end
  end

  task automatic check_direct(string t, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic send(int l, int r, int vl, int vr, bit m, bit s);
    @(negedge clk);
    in_valid = 1'b1; in_l = 24'(l); in_r = 24'(r);
    vol_l = 6'(vl); vol_r = 6'(vr); mute = m; swap = s;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic report();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R2: watchdog expired, actual hung expected finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_direct("R1 reset out_valid", int'(out_valid), 0);
    check_direct("R1 reset out_l", int'(out_l), 0);
    rst = 1'b0;
    @(negedge clk);
    check_direct("R1 first cycle out_r", int'(out_r), 0);

    tag = "R3 R4 gain sweep";
    for (int n = 0; n < 64; n++) send(8388607, -8388608, n, 63 - n, 0, 0);
    idle(3);
    check_direct("R4 code 0 on right held", int'(out_r), -8388608);
    send(8388607, 8388607, 0, 61, 0, 0); idle(3);
    check_direct("R3 code 0 passthrough", int'(out_l), 8388607);
    check_direct("R4 code 61 zero", int'(out_r), 0);

    tag = "R5 independent volumes";
    for (int i = 0; i < 20; i++) send(int'($urandom) >>> 8, int'($urandom) >>> 8, 3, 40, 0, 0);

    tag = "R6 swap";
    for (int i = 0; i < 20; i++) send(1000 * i, -700 * i, 6, 20, 0, 1);
    send(5000, -3, 0, 62, 0, 1); idle(3);
    check_direct("R6 swapped right to left", int'(out_l), -3);
    check_direct("R6 left to right with code 62", int'(out_r), 0);

    tag = "R7 rounding";
    for (int i = -4; i <= 4; i++) send(i, -i, 6, 1, 0, 0);
    for (int i = 0; i < 30; i++) send(int'($urandom) >>> 8, int'($urandom) >>> 8, i, 59 - i, 0, i % 2);

    tag = "R8 soft mute ramp";
    for (int i = 0; i < 40; i++) send(4000000, -4000000, 0, 0, 1, 0);
    idle(3);
    check_direct("R8 silent after ramp", int'(out_l), 0);

    tag = "R9 unmute ramp";
    for (int i = 0; i < 31; i++) send(4000000, -4000000, 0, 0, 0, 0);
    idle(3);
    check_direct("R9 one step short of unity", int'(out_l), 3875000);
    send(4000000, -4000000, 0, 0, 0, 0); idle(3);
    check_direct("R9 unity restored", int'(out_r), -4000000);

    tag = "R10 controls ignored when idle";
    send(123456, 654321, 10, 10, 0, 0);
    @(negedge clk);
    in_valid = 1'b0; vol_l = 6'd63; vol_r = 6'd63; swap = 1'b1; mute = 1'b1; in_l = 24'd1;
    idle(4);
    check_direct("R10 left held", int'(out_l), ref_out(123456, 10, 32));
    send(200000, 200000, 0, 0, 0, 0); idle(3);
    check_direct("R10 ramp kept full", int'(out_l), 200000);

    tag = "R2 bubbles and back-to-back";
    for (int i = 0; i < 30; i++) begin
      send(i * 3001 - 40000, 50000 - i * 777, i, i + 2, i > 20, i % 3 == 0);
      if (i % 4 == 1) idle(i % 3 + 1);
    end
    idle(4);
    report();
  end
endmodule